// File: doc/BRIEF.md
# Programmable CRC-32 Register Peripheral

A CRC engine that sits on a simple processor register bus. Software sets a seed, a 32-bit generator polynomial and a few control options. It then pushes message data into a data register and reads the running CRC back from that same register. Writes may be byte-wide or word-wide and may be mixed within one message. Each data write is absorbed in one clock cycle.

Each data write is fed through an optional input bit reversal: per byte, or across the whole word. The bits are then divided MSB first by the programmed polynomial, which has an implicit x^32 term. Reading the data register does not disturb the accumulator. Software can therefore save a partial CRC, reload it later as the seed, and carry on. This supports reflected algorithms such as CRC-32 and CRC-32C. Any final inversion is left to software.

Top module: `crc32_regblock`

## Requirements
- R1: After reset the control register reads 0x00000000, the seed register reads 0xFFFFFFFF, the polynomial register reads 0x04C11DB7, and the data register reads 0xFFFFFFFF.
- R2: A write to control (byte offset 0x08) with bit 0 set loads the seed register into the accumulator. Bit 0 always reads back as 0.
- R3: Control bits [6:5] select input reversal. 00 and 10 apply none. 01 reverses the bits within each byte. 11 reverses the whole 32-bit word. For a byte write, both 01 and 11 reverse the byte's 8 bits.
- R4: With control bit 7 set, a read of the data register (offset 0x00) returns the accumulator with its 32 bits reversed. With bit 7 clear, the read returns the accumulator unchanged.
- R5: A data write with strobes 4'b1111 feeds all 32 bits. A data write with exactly one strobe set feeds only the 8 bits of that lane. A data write with any other strobe pattern is ignored.
- R6: A data write is absorbed in one cycle, so a read in the next cycle already reflects it. Reading the data register leaves the accumulator unchanged.
- R7: The polynomial register (offset 0x14) is writable at run time. Both 0x04C11DB7 and 0x1EDC6F41 produce the standard reflected CRC-32 and CRC-32C check values.
- R8: Rewriting control with bit 0 clear changes the reversal mode without touching the accumulator, so byte writes and word writes can be interleaved within one message.
- R9: Writes to unmapped offsets change no register, and reads from unmapped offsets return 0.
- R10: The seed register (offset 0x10), the polynomial register and control bits [31:1] read back what was last written, whatever the strobes were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_rd | input | 1 | Read strobe for the current cycle |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte-lane strobes; only meaningful for data-register writes |
| bus_rdata | output | 32 | Read data, valid in the same cycle as bus_rd, 0 when idle |

## Verification
The bench builds the block with its default ADDR_W of 5 and the default reset values for seed and polynomial. That address width is just wide enough to decode every mapped offset, and it still leaves holes at 0x04, 0x0C and 0x1C for checking that unmapped accesses are ignored. Because the reset seed is all ones and the reset polynomial is the CRC-32 one, a known-answer CRC-32 run is possible straight out of reset. A second run then reprograms the polynomial for CRC-32C. A table of mixed-width writes, with the reversal mode changing from write to write, is compared against a bit-serial model written in the bench.

// File: rtl/crc32_regblock.sv
module crc32_regblock #(
  parameter int          ADDR_W   = 5,
  parameter logic [31:0] INIT_RST = 32'hFFFF_FFFF,
  parameter logic [31:0] POLY_RST = 32'h04C1_1DB7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  input  logic [3:0]        bus_be,
  output logic [31:0]       bus_rdata
);

  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(5'h00);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(5'h08);
  localparam logic [ADDR_W-1:0] A_SEED = ADDR_W'(5'h10);
  localparam logic [ADDR_W-1:0] A_POLY = ADDR_W'(5'h14);

  logic [31:0] acc_q, seed_q, poly_q;
  logic [31:1] ctrl_q;

  function automatic logic [31:0] rev32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  function automatic logic [31:0] feed(input logic [31:0] c, input logic [31:0] d,
                                       input logic nbyte, input logic [31:0] p);
    logic [31:0] r;
    logic        fb;
    r = c;
    for (int i = 31; i >= 0; i--) begin
      if (!nbyte || i >= 24) begin
        fb = r[31] ^ d[i];
        r  = {r[30:0], 1'b0} ^ (fb ? p : 32'h0);
      end
    end
    return r;
  endfunction

  wire [1:0] in_mode  = ctrl_q[6:5];
  wire       out_flip = ctrl_q[7];

  logic [7:0]  lane_byte;
  logic        byte_ok;
  logic [31:0] word_in;

  always_comb begin
    byte_ok   = 1'b1;
    lane_byte = bus_wdata[7:0];
    unique case (bus_be)
      4'b0001: lane_byte = bus_wdata[7:0];
      4'b0010: lane_byte = bus_wdata[15:8];
      4'b0100: lane_byte = bus_wdata[23:16];
      4'b1000: lane_byte = bus_wdata[31:24];
      default: byte_ok = 1'b0;
    endcase
  end

  always_comb begin
    case (in_mode)
      2'b11:   word_in = rev32(bus_wdata);
      2'b01:   word_in = {rev8(bus_wdata[31:24]), rev8(bus_wdata[23:16]),
                          rev8(bus_wdata[15:8]),  rev8(bus_wdata[7:0])};
      default: word_in = bus_wdata;
    endcase
  end

  wire [7:0]  byte_in  = in_mode[0] ? rev8(lane_byte) : lane_byte;
  wire [31:0] acc_word = feed(acc_q, word_in, 1'b0, poly_q);
  wire [31:0] acc_byte = feed(acc_q, {byte_in, 24'h0}, 1'b1, poly_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= INIT_RST;
      seed_q <= INIT_RST;
      poly_q <= POLY_RST;
      ctrl_q <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_DATA: begin
          if (bus_be == 4'b1111) acc_q <= acc_word;
          else if (byte_ok)      acc_q <= acc_byte;
        end
        A_CTRL: begin
          ctrl_q <= bus_wdata[31:1];
          if (bus_wdata[0]) acc_q <= seed_q;
        end
        A_SEED: seed_q <= bus_wdata;
        A_POLY: poly_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = 32'h0;
    if (bus_rd) begin
      case (bus_addr)
        A_DATA:  bus_rdata = out_flip ? rev32(acc_q) : acc_q;
        A_CTRL:  bus_rdata = {ctrl_q, 1'b0};
        A_SEED:  bus_rdata = seed_q;
        A_POLY:  bus_rdata = poly_q;
        default: bus_rdata = 32'h0;
      endcase
    end
  end

  wire mapped = (bus_addr == A_DATA) || (bus_addr == A_CTRL) ||
                (bus_addr == A_SEED) || (bus_addr == A_POLY);

  // R2
  seed_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CTRL && bus_wdata[0]) |=> (acc_q == $past(seed_q)));

  // R2
  ctrl_bit0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_CTRL) |-> (bus_rdata[0] == 1'b0));

  // R9
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !mapped) |=> ($stable(acc_q) && $stable(seed_q) &&
                             $stable(poly_q) && $stable(ctrl_q)));

  // R9
  unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !mapped) |-> (bus_rdata == 32'h0));

  // R6
  read_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !bus_wr) |=> $stable(acc_q));

  // R8
  mode_keeps_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == A_CTRL && !bus_wdata[0]) |=> $stable(acc_q));

endmodule

// File: tb/test_crc32_regblock.sv
module test_crc32_regblock;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  bus_be = '0;
  logic [31:0] bus_rdata;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2 clk = ~clk;

  crc32_regblock i_crc32_regblock (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata)
  );

  // {mode[1:0], is_byte, data[31:0]}
  localparam logic [34:0] VEC [8] = '{
    {2'b00, 1'b0, 32'hDEAD_BEEF},
    {2'b01, 1'b1, 32'h0000_00A5},
    {2'b11, 1'b0, 32'h1234_5678},
    {2'b01, 1'b0, 32'h0F0F_3C3C},
    {2'b00, 1'b1, 32'h0000_0081},
    {2'b10, 1'b0, 32'hCAFE_F00D},
    {2'b11, 1'b1, 32'h0000_0017},
    {2'b11, 1'b0, 32'h8000_0001}
  };

  logic [31:0] m_acc, m_poly;

  function automatic logic [31:0] flip32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[31-i] = v[i];
    return r;
  endfunction

  function automatic logic [7:0] flip8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[7-i] = v[i];
    return r;
  endfunction

  function automatic logic [31:0] m_bits(input logic [31:0] c, input logic [31:0] d,
                                         input int n, input logic [31:0] p);
    logic [31:0] r = c;
    for (int k = 0; k < n; k++) begin
      logic top = r[31] ^ d[31-k];
      r = r << 1;
      if (top) r = r ^ p;
    end
    return r;
  endfunction

  function automatic logic [31:0] m_word(input logic [31:0] c, input logic [31:0] w,
                                         input logic [1:0] md, input logic [31:0] p);
    logic [31:0] d = w;
    if (md == 2'b11) d = flip32(w);
    else if (md == 2'b01)
      for (int b = 0; b < 4; b++) d[8*b +: 8] = flip8(w[8*b +: 8]);
    return m_bits(c, d, 32, p);
  endfunction

  function automatic logic [31:0] m_byte(input logic [31:0] c, input logic [7:0] v,
                                         input logic [1:0] md, input logic [31:0] p);
    logic [7:0] b = md[0] ? flip8(v) : v;
    return m_bits(c, {b, 24'h0}, 8, p);
  endfunction

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(5'h08, v); check("R1 ctrl", v, 32'h0);
    rd(5'h10, v); check("R1 seed", v, 32'hFFFF_FFFF);
    rd(5'h14, v); check("R1 poly", v, 32'h04C1_1DB7);
    rd(5'h00, v); check("R1 data", v, 32'hFFFF_FFFF);

    // R7 CRC-32 check value, words then a trailing byte; R3 R4 R5 R8
    wr(5'h08, 32'h0000_00E1, 4'b1111);
    wr(5'h00, 32'h3433_3231, 4'b1111);
    wr(5'h00, 32'h3837_3635, 4'b1111);
    wr(5'h08, 32'h0000_00A0, 4'b1111);
    wr(5'h00, 32'h0000_0039, 4'b0001);
    rd(5'h00, v); check("R7 crc32", ~v, 32'hCBF4_3926);
    rd(5'h08, v); check("R2 bit0 reads 0", v, 32'h0000_00A0);

    // R7 CRC-32C with a run-time polynomial, all bytes on lane 2
    wr(5'h14, 32'h1EDC_6F41, 4'b0001);
    rd(5'h14, v); check("R10 poly", v, 32'h1EDC_6F41);
    wr(5'h08, 32'h0000_00A1, 4'b1111);
    for (int i = 0; i < 9; i++) wr(5'h00, (32'h31 + i) << 16, 4'b0100);
    rd(5'h00, v); check("R7 crc32c", ~v, 32'hE306_9283);

    // R6 read does not disturb
    rd(5'h00, v); check("R6 reread", ~v, 32'hE306_9283);

    // Table walk: R3 R5 R8 R6, vs model, no reset between entries
    wr(5'h14, 32'h04C1_1DB7, 4'b1111);
    wr(5'h10, 32'h5A5A_0F0F, 4'b0010);
    rd(5'h10, v); check("R10 seed", v, 32'h5A5A_0F0F);
    wr(5'h08, 32'h0000_0001, 4'b1111);
    rd(5'h00, v); check("R2 seed load", v, 32'h5A5A_0F0F);
    m_acc = 32'h5A5A_0F0F; m_poly = 32'h04C1_1DB7;
    for (int i = 0; i < 8; i++) begin
      logic [1:0] md = VEC[i][34:33];
      wr(5'h08, {25'h0, md, 5'h0}, 4'b1111);
      if (VEC[i][32]) begin
        wr(5'h00, VEC[i][31:0], 4'b0001);
        m_acc = m_byte(m_acc, VEC[i][7:0], md, m_poly);
      end else begin
        wr(5'h00, VEC[i][31:0], 4'b1111);
        m_acc = m_word(m_acc, VEC[i][31:0], md, m_poly);
      end
      rd(5'h00, v); check("R3 R5 R8 table", v, m_acc);
    end

    // R4 output reversal
    wr(5'h08, 32'h0000_0080, 4'b1111);
    rd(5'h00, v); check("R4 out reversed", v, flip32(m_acc));

    // R5 byte on lane 3, then an illegal strobe pattern ignored
    wr(5'h08, 32'h0000_0000, 4'b1111);
    wr(5'h00, 32'hC300_0000, 4'b1000);
    m_acc = m_byte(m_acc, 8'hC3, 2'b00, m_poly);
    rd(5'h00, v); check("R5 lane3", v, m_acc);
    wr(5'h00, 32'hFFFF_FFFF, 4'b0011);
    rd(5'h00, v); check("R5 bad strobes ignored", v, m_acc);

    // R9 unmapped accesses
    wr(5'h04, 32'h1234_5678, 4'b1111);
    wr(5'h1C, 32'h0000_0001, 4'b1111);
    rd(5'h04, v); check("R9 read hole", v, 32'h0);
    rd(5'h00, v); check("R9 data kept", v, m_acc);
    rd(5'h10, v); check("R9 seed kept", v, 32'h5A5A_0F0F);
    rd(5'h08, v); check("R9 ctrl kept", v, 32'h0);

    // R10 upper ctrl bits read back
    wr(5'h08, 32'hF000_0061, 4'b0001);
    rd(5'h08, v); check("R10 ctrl", v, 32'hF000_0060);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule